// File: doc/BRIEF.md
# Crosspoint Switch Control Memory

This block stores the on/off state of every crosspoint in a switch matrix of 8 columns by 4 rows. There are 32 enable bits, one per crosspoint. A controller picks one crosspoint with a column address and a row address and drives the desired state on a single data line. The write takes effect while both the select input and the strobe are high. A master reset turns every crosspoint off at once.

Each storage bit behaves like a resettable transparent latch. The model samples it on the block clock:

- In any cycle where select and strobe are both high at the rising edge, the addressed bit takes the data value.
- The last value taken before strobe (or select) drops stays in the bit.
- Reset is asynchronous and active high. It overrides any write in progress.

Several arrays can be cascaded outside the block. They share address, data and strobe, and each array gets its own select line.

Top module: `xpt_ctrl_array`

## Requirements
- R1: While `rst` is high, all 32 bits of `sw_en` are 0. The clear happens without waiting for a clock edge, and it happens whatever the level of `chip_sel`.
- R2: If `chip_sel` and `strobe` are both high at a rising clock edge, the addressed bit of `sw_en` equals the sampled `wr_data` after that edge.
- R3: A write changes only the addressed bit. Every other bit of `sw_en` keeps its value.
- R4: If `chip_sel` is low at an edge, no bit changes, whatever `strobe`, `wr_data` and the address do.
- R5: After `strobe` falls, the addressed bit keeps the last value written while `strobe` was high. Later changes on `wr_data` do not alter it.
- R6: The bit index is row × 8 + column. Bit 0 is row 0, column 0, and bit 31 is row 3, column 7.
- R7: While `chip_sel` and `strobe` stay high, the addressed bit follows `wr_data` cycle by cycle.
- R8: While `rst` is high, an active write (select and strobe high) leaves the bit at 0.
- R9: Writing 1 turns a crosspoint on (bit = 1), and writing 0 turns it off (bit = 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for the control inputs |
| rst | input | 1 | Asynchronous master clear, active high |
| col_addr | input | 3 | Column number of the addressed crosspoint |
| row_addr | input | 2 | Row number of the addressed crosspoint |
| wr_data | input | 1 | Value to store: 1 = on, 0 = off |
| chip_sel | input | 1 | Enables writes to this array, active high |
| strobe | input | 1 | Write strobe, active high |
| sw_en | output | 32 | Crosspoint enables, index row × 8 + column |

## Verification
The hardest case to reach is reset arriving while a write is open. Here the clear must beat the open latch both between clock edges and at the edges that follow. The stimulus holds select and strobe high with data 1 and raises reset part way through a clock low phase. It samples the output before the next edge, and again after an edge with the write still active. It then closes the write before releasing reset. A second case holds the strobe open and toggles data over several cycles, then changes data after the strobe falls. This shows that the bit follows data while the strobe is open and keeps the last value once it closes.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
    localparam int unsigned XPT_COLS = 8;
    localparam int unsigned XPT_ROWS = 4;
endpackage

// File: rtl/xpt_addr_decode.sv
module xpt_addr_decode #(
    parameter int unsigned COLS = 8,
    parameter int unsigned ROWS = 4,
    localparam int unsigned COL_W = $clog2(COLS),
    localparam int unsigned ROW_W = $clog2(ROWS),
    localparam int unsigned CELLS = COLS * ROWS,
    localparam int unsigned IDX_W = $clog2(CELLS)
) (
    input  logic [COL_W-1:0] col_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic             en_i,
    output logic [IDX_W-1:0] idx_o,
    output logic [CELLS-1:0] sel_o
);
    // linear index: row major, columns within a row
    assign idx_o = IDX_W'(row_i) * IDX_W'(COLS) + IDX_W'(col_i);

    for (genvar g = 0; g < CELLS; g++) begin : g_sel
        assign sel_o[g] = en_i && (idx_o == IDX_W'(g));
    end
endmodule

// File: rtl/xpt_latch_bank.sv
module xpt_latch_bank #(
    parameter int unsigned CELLS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CELLS-1:0] sel_i,
    input  logic             din_i,
    output logic [CELLS-1:0] bits_o
);
    typedef struct packed {
        logic [CELLS-1:0] bits;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < CELLS; i++) begin
            if (sel_i[i]) begin
                bank_d.bits[i] = din_i;
            end
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign bits_o = bank_q.bits;
endmodule

// File: rtl/xpt_ctrl_array.sv
module xpt_ctrl_array
    import xpt_pkg::*;
#(
    parameter int unsigned COLS = XPT_COLS,
    parameter int unsigned ROWS = XPT_ROWS,
    localparam int unsigned COL_W = $clog2(COLS),
    localparam int unsigned ROW_W = $clog2(ROWS),
    localparam int unsigned CELLS = COLS * ROWS,
    localparam int unsigned IDX_W = $clog2(CELLS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [COL_W-1:0] col_addr,
    input  logic [ROW_W-1:0] row_addr,
    input  logic             wr_data,
    input  logic             chip_sel,
    input  logic             strobe,
    output logic [CELLS-1:0] sw_en
);
    logic             gate_open;
    logic [IDX_W-1:0] wr_idx;
    logic [CELLS-1:0] cell_sel;

    // latch enable: select AND strobe, then AND the decoded address
    assign gate_open = chip_sel & strobe;

    xpt_addr_decode #(.COLS(COLS), .ROWS(ROWS)) u_decode (
        .col_i (col_addr),
        .row_i (row_addr),
        .en_i  (gate_open),
        .idx_o (wr_idx),
        .sel_o (cell_sel)
    );

    xpt_latch_bank #(.CELLS(CELLS)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .sel_i  (cell_sel),
        .din_i  (wr_data),
        .bits_o (sw_en)
    );

    // R1, R8: reset held across an edge leaves every bit cleared
    p_reset_clears_r1: assert property (@(posedge clk)
        (rst && $past(rst)) |-> (sw_en == '0));

    // R2: written bit takes sampled data
    p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
        (chip_sel && strobe) |=> (((sw_en >> $past(wr_idx)) & CELLS'(1)) == CELLS'($past(wr_data))));

    // R3: neighbours of the written bit untouched
    p_others_kept_r3: assert property (@(posedge clk) disable iff (rst)
        (chip_sel && strobe) |=> (((sw_en ^ $past(sw_en)) & ~(CELLS'(1) << $past(wr_idx))) == '0));

    // R4, R5: closed gate keeps the array still
    p_hold_when_closed_r4: assert property (@(posedge clk) disable iff (rst)
        !(chip_sel && strobe) |=> $stable(sw_en));
endmodule

// File: tb/xpt_ctrl_array_bench.sv
`timescale 1ns/1ps
module xpt_ctrl_array_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  col_addr = '0;
    logic [1:0]  row_addr = '0;
    logic        wr_data = 1'b0;
    logic        chip_sel = 1'b0;
    logic        strobe = 1'b0;
    logic [31:0] sw_en;
    logic [31:0] exp_v = '0;
    int          n_chk = 0;
    int          n_fail = 0;

    always #2.5 clk = ~clk;

    xpt_ctrl_array u_xpt_ctrl_array (
        .clk(clk), .rst(rst), .col_addr(col_addr), .row_addr(row_addr),
        .wr_data(wr_data), .chip_sel(chip_sel), .strobe(strobe), .sw_en(sw_en)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_write(input int row, input int col, input bit d, input string req);
        @(negedge clk);
        row_addr = 2'(row); col_addr = 3'(col); wr_data = d; chip_sel = 1'b1;
        @(negedge clk);
        strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0; chip_sel = 1'b0;
        exp_v[row*8+col] = d;
        @(negedge clk);
        chk(sw_en == exp_v, req, sw_en, exp_v);
    endtask

    task automatic t_reset_state();
        chk(sw_en == '0, "R1 reset state", sw_en, '0);
    endtask

    task automatic t_corner_writes();
        do_write(0, 0, 1'b1, "R6 bit0 row0 col0");
        do_write(3, 7, 1'b1, "R6 bit31 row3 col7");
        do_write(1, 2, 1'b1, "R2 R3 bit10");
        do_write(2, 0, 1'b1, "R6 bit16");
        do_write(1, 2, 1'b0, "R9 clear bit10");
        do_write(0, 7, 1'b1, "R9 set bit7");
        chk(sw_en[31] && sw_en[0] && !sw_en[10], "R9 on/off states", sw_en, exp_v);
    endtask

    task automatic t_cs_low();
        @(negedge clk);
        row_addr = 2'd1; col_addr = 3'd5; wr_data = 1'b1; chip_sel = 1'b0;
        @(negedge clk); strobe = 1'b1;
        @(negedge clk); row_addr = 2'd3; col_addr = 3'd7; wr_data = 1'b0;
        @(negedge clk); strobe = 1'b0; wr_data = 1'b1;
        @(negedge clk);
        chk(sw_en == exp_v, "R4 cs low no change", sw_en, exp_v);
        chk(!sw_en[13], "R4 bit13 still off", sw_en, exp_v);
    endtask

    task automatic t_follow_and_capture();
        @(negedge clk);
        row_addr = 2'd2; col_addr = 3'd5; chip_sel = 1'b1; wr_data = 1'b1; strobe = 1'b1;
        @(negedge clk);
        chk(sw_en[21] == 1'b1, "R7 follows data 1", sw_en, exp_v | 32'h0020_0000);
        wr_data = 1'b0;
        @(negedge clk);
        chk(sw_en[21] == 1'b0, "R7 follows data 0", sw_en, exp_v);
        wr_data = 1'b1;
        @(negedge clk);
        chk(sw_en[21] == 1'b1, "R7 follows data 1 again", sw_en, exp_v | 32'h0020_0000);
        strobe = 1'b0;
        @(negedge clk);
        wr_data = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chip_sel = 1'b0;
        exp_v[21] = 1'b1;
        chk(sw_en == exp_v, "R5 value kept after strobe falls", sw_en, exp_v);
    endtask

    task automatic t_reset_during_write();
        @(negedge clk);
        row_addr = 2'd0; col_addr = 3'd3; wr_data = 1'b1; chip_sel = 1'b1; strobe = 1'b1;
        @(negedge clk);
        chk(sw_en[3] == 1'b1, "R2 write before reset", sw_en, exp_v | 32'h8);
        #1 rst = 1'b1;
        #0.5;
        chk(sw_en == '0, "R1 async clear mid write", sw_en, '0);
        @(negedge clk);
        chk(sw_en == '0, "R8 reset beats open write", sw_en, '0);
        strobe = 1'b0; chip_sel = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        exp_v = '0;
        @(negedge clk);
        chk(sw_en == '0, "R1 cleared after release", sw_en, '0);
    endtask

    task automatic t_reset_between_writes();
        do_write(3, 1, 1'b1, "R2 write bit25");
        do_write(1, 6, 1'b1, "R2 write bit14");
        @(negedge clk);
        chip_sel = 1'b0;
        #1 rst = 1'b1;
        #0.5;
        chk(sw_en == '0, "R1 clear with cs low", sw_en, '0);
        @(negedge clk);
        rst = 1'b0;
        exp_v = '0;
        @(negedge clk);
        chk(sw_en == '0, "R1 stays clear", sw_en, '0);
        do_write(2, 7, 1'b1, "R2 write after reset");
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        rst = 1'b0;
        @(negedge clk);
        t_corner_writes();
        t_cs_low();
        t_follow_and_capture();
        t_reset_during_write();
        t_reset_between_writes();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule